// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through data cache and the next level of memory and holds stores that have not yet been written out. Storage is a small ring of entries, each covering one aligned block of four words with a valid flag per word. A store whose block is already held in an entry that is still open takes that entry's word slot instead of using a fresh entry, so a run of stores to neighbouring words costs one memory transaction instead of several.

Entries leave in allocation order. The oldest entry is locked for draining in the first cycle in which it is occupied and no accepted store writes into it. From then on it is shown on the memory side as one transaction: block address, all four data words and a four-bit word mask, held until memory accepts it. A store to the block of a locked entry opens a new entry. When every entry is taken and the store matches no open entry, the store port stalls. A plain hit check tells whether a given word is currently held.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset `stReady` is 1, `memValid` is 0 and `rdHit` is 0.
- R2: Byte address bits [3:2] select the word and bits [31:4] the block. Back-to-back stores to the four words of one block merge into one entry, which drains once with `memMask` = 4'b1111.
- R3: A store to a word that is already valid in an open entry replaces it, so the newest data drains.
- R4: Stores to different blocks take separate entries, each draining with only its own word bits set in `memMask`.
- R5: Entries drain in the order in which they were allocated.
- R6: A drain shows `memAddr` as the block's byte address with bits [3:0] zero, word i on `memData[32*i+31:32*i]` and its valid flag on `memMask[i]`. `memValid` and the whole payload stay unchanged until `memReady` is 1.
- R7: The oldest entry locks in the first cycle it is occupied and not written. A later store to a locked entry's block does not change that drain and allocates a new entry.
- R8: Sixteen back-to-back word stores covering four blocks are all accepted with `stReady` high throughout while memory accepts nothing.
- R9: With all four entries taken, a store to a block held in no open entry sees `stReady` = 0 until an entry drains. A store to a block held in an open entry is still accepted.
- R10: `rdHit` is 1 exactly when some held entry has the word addressed by `rdAddr` valid, including an entry that is waiting to drain.
- R11: A drain completing and a store being accepted in the same cycle both take effect, with no store lost and no entry drained twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stValid | input | 1 | A store is offered |
| stReady | output | 1 | The offered store is taken at this edge |
| stAddr | input | 32 | Store byte address |
| stData | input | 32 | Store data word |
| rdAddr | input | 32 | Byte address for the hit check |
| rdHit | output | 1 | That word is held in the buffer |
| memValid | output | 1 | A drain transaction is offered |
| memReady | input | 1 | Memory accepts the drain at this edge |
| memAddr | output | 32 | Block byte address of the drain |
| memData | output | 128 | Four data words of the drained entry |
| memMask | output | 4 | Valid flag of each drained word |

## Verification
Two pairs of events can fall in the same cycle. A drain completing can coincide with a new store being taken. The bench provokes this by streaming stores to distinct blocks while memory accepts constantly, and by releasing a full stall at the moment memory takes the oldest entry. The scoreboard judges the result by requiring every expected drain, in order, with nothing missing or repeated. The second pair is a store landing in the oldest entry in the cycle that entry would otherwise lock. Back-to-back stores to one block must still merge, and a store arriving after an idle cycle must open a new entry.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  parameter int unsigned MWB_ENTRIES = 4;
  parameter int unsigned MWB_WORDS   = 4;
  localparam int unsigned MWB_IDX_W  = $clog2(MWB_ENTRIES);
  localparam int unsigned MWB_WSEL_W = $clog2(MWB_WORDS);
  localparam int unsigned MWB_CNT_W  = MWB_IDX_W + 1;

  typedef struct packed {
    logic                 allocEn;
    logic                 mergeEn;
    logic [MWB_IDX_W-1:0] wrIdx;
    logic                 popEn;
    logic [MWB_IDX_W-1:0] popIdx;
  } mwb_ctrl_t;
endpackage

// File: rtl/mwb_datapath.sv
module mwb_datapath
  import mwb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             stAddr,
  input  logic [DATA_W-1:0]             stData,
  input  mwb_ctrl_t                     ctrl,
  input  logic [MWB_IDX_W-1:0]          headIdx,
  input  logic                          headLocked,
  input  logic [ADDR_W-1:0]             rdAddr,
  output logic [MWB_ENTRIES-1:0]        matchVec,
  output logic                          rdHit,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [DATA_W*MWB_WORDS-1:0]   memData,
  output logic [MWB_WORDS-1:0]          memMask
);
  localparam int unsigned OFF_W = $clog2(DATA_W / 8);
  localparam int unsigned BLK_W = ADDR_W - MWB_WSEL_W - OFF_W;
  localparam int unsigned LOW_W = MWB_WSEL_W + OFF_W;

  logic [BLK_W-1:0]     blkQ  [MWB_ENTRIES];
  logic [MWB_WORDS-1:0] maskQ [MWB_ENTRIES];
  logic [DATA_W-1:0]    dataQ [MWB_ENTRIES][MWB_WORDS];
  logic [MWB_ENTRIES-1:0] occQ;

  logic [BLK_W-1:0]      stBlk, rdBlk;
  logic [MWB_WSEL_W-1:0] stWord, rdWord;
  logic [MWB_WORDS-1:0]  stOneHot;

  assign stBlk  = stAddr[ADDR_W-1 -: BLK_W];
  assign stWord = stAddr[OFF_W +: MWB_WSEL_W];
  assign rdBlk  = rdAddr[ADDR_W-1 -: BLK_W];
  assign rdWord = rdAddr[OFF_W +: MWB_WSEL_W];

  always_comb begin
    stOneHot = '0;
    stOneHot[stWord] = 1'b1;
  end

  // Block compare per entry; a locked head is closed to merging.
  for (genvar e = 0; e < MWB_ENTRIES; e++) begin : g_match
    assign matchVec[e] = occQ[e] && (blkQ[e] == stBlk) &&
                         !(headLocked && (headIdx == MWB_IDX_W'(e)));
  end

  always_comb begin
    rdHit = 1'b0;
    for (int e = 0; e < MWB_ENTRIES; e++) begin
      if (occQ[e] && (blkQ[e] == rdBlk) && maskQ[e][rdWord]) rdHit = 1'b1;
    end
  end

  // Entry tags and word masks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occQ <= '0;
      for (int e = 0; e < MWB_ENTRIES; e++) begin
        blkQ[e]  <= '0;
        maskQ[e] <= '0;
      end
    end else begin
      for (int e = 0; e < MWB_ENTRIES; e++) begin
        if (ctrl.popEn && (ctrl.popIdx == MWB_IDX_W'(e))) begin
          occQ[e]  <= 1'b0;
          maskQ[e] <= '0;
        end
        if (ctrl.allocEn && (ctrl.wrIdx == MWB_IDX_W'(e))) begin
          occQ[e]  <= 1'b1;
          blkQ[e]  <= stBlk;
          maskQ[e] <= stOneHot;
        end else if (ctrl.mergeEn && (ctrl.wrIdx == MWB_IDX_W'(e))) begin
          maskQ[e] <= maskQ[e] | stOneHot;
        end
      end
    end
  end

  // Word storage, no reset needed: only masked words are ever consumed
  always_ff @(posedge clk) begin
    for (int e = 0; e < MWB_ENTRIES; e++) begin
      if ((ctrl.allocEn || ctrl.mergeEn) && (ctrl.wrIdx == MWB_IDX_W'(e)))
        dataQ[e][stWord] <= stData;
    end
  end

  assign memAddr = {blkQ[headIdx], {LOW_W{1'b0}}};
  assign memMask = maskQ[headIdx];
  always_comb begin
    for (int w = 0; w < MWB_WORDS; w++) memData[w*DATA_W +: DATA_W] = dataQ[headIdx][w];
  end

  // R4: allocation only lands in a free slot
  p_alloc_free_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.allocEn |-> !occQ[ctrl.wrIdx]);

  // R7: a merge never touches a locked entry
  p_merge_open_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.mergeEn |-> (occQ[ctrl.wrIdx] && !(headLocked && ctrl.wrIdx == headIdx)));

  // R6: locked payload is frozen until accepted
  p_payload_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (headLocked && !ctrl.popEn) |=>
      ($stable(memAddr) && $stable(memMask) && $stable(memData)));
endmodule

// File: rtl/mwb_ctrl.sv
module mwb_ctrl
  import mwb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   stValid,
  input  logic [MWB_ENTRIES-1:0] matchVec,
  input  logic                   memReady,
  output logic                   stReady,
  output logic                   memValid,
  output mwb_ctrl_t              ctrl,
  output logic [MWB_IDX_W-1:0]   headIdx,
  output logic                   headLocked
);
  logic [MWB_IDX_W-1:0] headQ, tailQ, matchIdx;
  logic [MWB_CNT_W-1:0] cntQ;
  logic lockQ, anyMatch, full, accept, headHit, pop;

  function automatic logic [MWB_IDX_W-1:0] nextPtr(input logic [MWB_IDX_W-1:0] p);
    if (p == MWB_IDX_W'(MWB_ENTRIES - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    matchIdx = '0;
    for (int e = 0; e < MWB_ENTRIES; e++) if (matchVec[e]) matchIdx = MWB_IDX_W'(e);
  end

  assign anyMatch = |matchVec;
  assign full     = (cntQ == MWB_CNT_W'(MWB_ENTRIES));
  assign stReady  = anyMatch || !full;
  assign accept   = stValid && stReady;
  assign headHit  = accept && matchVec[headQ];
  assign pop      = lockQ && memReady;

  always_comb begin
    ctrl.mergeEn = accept && anyMatch;
    ctrl.allocEn = accept && !anyMatch;
    ctrl.wrIdx   = anyMatch ? matchIdx : tailQ;
    ctrl.popEn   = pop;
    ctrl.popIdx  = headQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
      cntQ  <= '0;
      lockQ <= 1'b0;
    end else begin
      if (ctrl.allocEn) tailQ <= nextPtr(tailQ);
      if (pop)          headQ <= nextPtr(headQ);
      if (ctrl.allocEn && !pop)      cntQ <= cntQ + 1'b1;
      else if (!ctrl.allocEn && pop) cntQ <= cntQ - 1'b1;
      if (pop)                                         lockQ <= 1'b0;
      else if (!lockQ && (cntQ != '0) && !headHit)     lockQ <= 1'b1;
    end
  end

  assign memValid   = lockQ;
  assign headIdx    = headQ;
  assign headLocked = lockQ;

  // R9: occupancy never exceeds the entry count
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= MWB_CNT_W'(MWB_ENTRIES));

  // R9: the store port stalls only when every entry is taken
  p_stall_when_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stReady |-> full);

  // R6: an offered drain is held until accepted
  p_hold_offer_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> memValid);

  // R11: simultaneous allocate and drain leave occupancy unchanged
  p_count_balance_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.allocEn && pop) |=> (cntQ == $past(cntQ)));
endmodule

// File: rtl/merge_write_buffer.sv
module merge_write_buffer
  import mwb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        stValid,
  output logic                        stReady,
  input  logic [ADDR_W-1:0]           stAddr,
  input  logic [DATA_W-1:0]           stData,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic                        rdHit,
  output logic                        memValid,
  input  logic                        memReady,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [DATA_W*MWB_WORDS-1:0] memData,
  output logic [MWB_WORDS-1:0]        memMask
);
  mwb_ctrl_t              ctrl;
  logic [MWB_ENTRIES-1:0] matchVec;
  logic [MWB_IDX_W-1:0]   headIdx;
  logic                   headLocked;

  mwb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .matchVec(matchVec),
    .memReady(memReady), .stReady(stReady), .memValid(memValid),
    .ctrl(ctrl), .headIdx(headIdx), .headLocked(headLocked)
  );

  mwb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stAddr(stAddr), .stData(stData), .ctrl(ctrl),
    .headIdx(headIdx), .headLocked(headLocked), .rdAddr(rdAddr),
    .matchVec(matchVec), .rdHit(rdHit), .memAddr(memAddr),
    .memData(memData), .memMask(memMask)
  );

  // R1: nothing is offered to memory right after reset
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !memValid);
endmodule

// File: tb/merge_write_buffer_tb.sv
module merge_write_buffer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stValid = 1'b0;
  logic [31:0] stAddr = '0, stData = '0, rdAddr = '0;
  logic memReady = 1'b0;
  logic stReady, rdHit, memValid;
  logic [31:0] memAddr;
  logic [127:0] memData;
  logic [3:0] memMask;

  int checks = 0;
  int errors = 0;
  int stalls = 0;

  logic [31:0]  expAddrQ[$];
  logic [3:0]   expMaskQ[$];
  logic [127:0] expDataQ[$];
  string        expTagQ[$];

  always #2 clk = ~clk;

  merge_write_buffer dut_i (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .rdAddr(rdAddr), .rdHit(rdHit),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memData(memData), .memMask(memMask)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver side of the scoreboard
  task automatic expDrain(input logic [31:0] a, input logic [3:0] m,
                          input logic [31:0] d0, input logic [31:0] d1,
                          input logic [31:0] d2, input logic [31:0] d3, input string tag);
    expAddrQ.push_back(a);
    expMaskQ.push_back(m);
    expDataQ.push_back({d3, d2, d1, d0});
    expTagQ.push_back(tag);
  endtask

  // Monitor: compare each accepted drain against the oldest expectation
  always @(negedge clk) begin
    if (rstN && memValid && memReady) begin
      if (expAddrQ.size() == 0) begin
        chk(1'b0, "R11 unexpected drain", {96'b0, memAddr}, 128'b0);
      end else begin
        logic [31:0]  ea;
        logic [3:0]   em;
        logic [127:0] ed, wm;
        string        tg;
        ea = expAddrQ.pop_front();
        em = expMaskQ.pop_front();
        ed = expDataQ.pop_front();
        tg = expTagQ.pop_front();
        wm = {{32{em[3]}}, {32{em[2]}}, {32{em[1]}}, {32{em[0]}}};
        chk(memAddr == ea, {tg, " R5 address"}, {96'b0, memAddr}, {96'b0, ea});
        chk(memMask == em, {tg, " R6 mask"}, {124'b0, memMask}, {124'b0, em});
        chk((memData & wm) == (ed & wm), {tg, " R6 data"}, memData & wm, ed & wm);
      end
    end
  end

  // Presents a store from posedge+1 and returns just after the edge that takes it
  task automatic storeW(input logic [31:0] a, input logic [31:0] d);
    stValid = 1'b1;
    stAddr  = a;
    stData  = d;
    @(negedge clk);
    if (!stReady) stalls++;
    while (!stReady) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic idleStore();
    stValid = 1'b0;
  endtask

  task automatic drainAll(input string tag);
    int n;
    memReady = 1'b1;
    n = 0;
    while (expAddrQ.size() != 0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    @(posedge clk);
    #1;
    memReady = 1'b0;
    chk(expAddrQ.size() == 0, {tag, " all expected drains seen"}, 128'(expAddrQ.size()), 128'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog expired", 128'd0, 128'd1);
    finishRun();
  end

  initial begin
    logic [31:0] sa;
    logic [3:0]  sm;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(stReady == 1'b1, "R1 stReady after reset", 128'(stReady), 128'd1);
    chk(memValid == 1'b0, "R1 memValid after reset", 128'(memValid), 128'd0);
    rdAddr = 32'h104;
    #0 chk(rdHit == 1'b0, "R1 rdHit after reset", 128'(rdHit), 128'd0);
    @(posedge clk);
    #1;

    // R2 merge of four neighbouring words, R10 hit check
    storeW(32'h100, 32'hA0);
    storeW(32'h104, 32'hA1);
    storeW(32'h108, 32'hA2);
    storeW(32'h10C, 32'hA3);
    idleStore();
    rdAddr = 32'h108;
    @(negedge clk);
    chk(rdHit == 1'b1, "R10 hit on held word", 128'(rdHit), 128'd1);
    rdAddr = 32'h208;
    #1 chk(rdHit == 1'b0, "R10 miss on other block", 128'(rdHit), 128'd0);
    @(negedge clk);
    chk(memValid == 1'b1, "R7 head locked after idle cycle", 128'(memValid), 128'd1);
    sa = memAddr;
    sm = memMask;
    @(negedge clk);
    chk(memValid && memAddr == sa && memMask == sm, "R6 offer held while not ready",
        {92'b0, memMask, memAddr}, {92'b0, sm, sa});
    @(posedge clk);
    #1;
    // R7 store to a locked block opens a new entry
    storeW(32'h104, 32'hB1);
    idleStore();
    @(negedge clk);
    chk(memMask == 4'hF, "R7 locked drain unchanged", 128'(memMask), 128'hF);
    expDrain(32'h100, 4'hF, 32'hA0, 32'hA1, 32'hA2, 32'hA3, "R2 merged block");
    expDrain(32'h100, 4'h2, 32'h0, 32'hB1, 32'h0, 32'h0, "R7 new entry after lock");
    @(posedge clk);
    #1;
    drainAll("R2");
    rdAddr = 32'h104;
    @(negedge clk);
    chk(rdHit == 1'b0, "R10 no hit after drain", 128'(rdHit), 128'd0);
    @(posedge clk);
    #1;

    // R3 newest data wins
    storeW(32'h300, 32'hD1);
    storeW(32'h304, 32'hD2);
    storeW(32'h300, 32'hD3);
    idleStore();
    expDrain(32'h300, 4'h3, 32'hD3, 32'hD2, 32'h0, 32'h0, "R3 overwrite");
    drainAll("R3");

    // R4 separate blocks, R5 order
    storeW(32'h404, 32'hC0);
    storeW(32'h508, 32'hC1);
    storeW(32'h60C, 32'hC2);
    idleStore();
    expDrain(32'h400, 4'h2, 32'h0, 32'hC0, 32'h0, 32'h0, "R4 first block");
    expDrain(32'h500, 4'h4, 32'h0, 32'h0, 32'hC1, 32'h0, "R4 second block");
    expDrain(32'h600, 4'h8, 32'h0, 32'h0, 32'h0, 32'hC2, "R5 third block");
    drainAll("R4");

    // R8 sixteen stores fit, R9 full stall and merge while full
    stalls = 0;
    for (int i = 0; i < 16; i++) storeW(32'h1000 + 32'(4 * i), 32'h5000 + 32'(i));
    chk(stalls == 0, "R8 no stall over sixteen stores", 128'(stalls), 128'd0);
    storeW(32'h1034, 32'h6000);
    chk(stalls == 0, "R9 merge accepted while full", 128'(stalls), 128'd0);
    stValid = 1'b1;
    stAddr  = 32'h2000;
    stData  = 32'h7000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(stReady == 1'b0, "R9 stall when full", 128'(stReady), 128'd0);
    end
    for (int b = 0; b < 4; b++)
      expDrain(32'h1000 + 32'(16 * b), 4'hF, 32'h5000 + 32'(4 * b),
               (b == 3) ? 32'h6000 : 32'h5001 + 32'(4 * b),
               32'h5002 + 32'(4 * b), 32'h5003 + 32'(4 * b), "R8 full block");
    expDrain(32'h2000, 4'h1, 32'h7000, 32'h0, 32'h0, 32'h0, "R9 store after stall");
    @(posedge clk);
    #1 memReady = 1'b1;
    @(negedge clk);
    while (!stReady) @(negedge clk);
    @(posedge clk);
    #1 idleStore();
    drainAll("R9");

    // R11 stores accepted while drains complete
    memReady = 1'b1;
    for (int i = 0; i < 8; i++) begin
      storeW(32'h3000 + 32'(16 * i), 32'h8000 + 32'(i));
      expDrain(32'h3000 + 32'(16 * i), 4'h1, 32'h8000 + 32'(i), 32'h0, 32'h0, 32'h0,
               "R11 overlapped store and drain");
    end
    idleStore();
    drainAll("R11");
    repeat (4) @(negedge clk);
    chk(memValid == 1'b0, "R11 empty after streaming", 128'(memValid), 128'd0);
    finishRun();
  end
endmodule